// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment descriptors for a 64-bit MMU that walks a hashed page table. Each slot pairs a tag word with a data word. The tag word holds an effective segment ID and a valid bit. The data word holds a segment-size field, protection key bits, a no-execute bit, a large-page bit and the virtual segment ID. Each slot is configured as either a 256 MB or a 1 TB segment, and a combinational lookup port compares an effective address against both segment sizes at once.

A single command port serves five operations: write a slot, read the tag half of a slot, read the data half of a slot, invalidate by address, and invalidate everything except slot 0. Every command produces a registered response one cycle later, carrying an error flag and any read data. When an invalidate actually removes a live segment, the block raises a one-cycle flush request for the downstream translation cache, which must then drop its stale translations.

Top module: `slb_array`

## Requirements
- R1: A lookup hits a valid slot (tag bit 27 set) in two cases. The first is when the slot's size field (data bits 63:62) is 00 (256 MB) and tag bits 63:28 equal the address bits 63:28. The second is when the size field is 01 (1 TB) and tag bits 63:40 equal the address bits 63:40 while tag bits 39:28 are zero.
- R2: A write takes its slot from address bits 11:0 and is rejected with an error if any of those bits at or above log2(NUM_ENTRIES) is set. A rejected write changes no slot.
- R3: A write is rejected with an error, changing no slot, in either of two cases: the data size field is 10 or 11, or the field is 01 while seg1t_en_i is low.
- R4: An accepted write stores the address operand with every bit cleared except bits 63:28 and bit 27, and stores the data operand unchanged.
- R5: Invalidate-all clears only the valid bit of slots 1 to NUM_ENTRIES-1. Slot 0 is never changed.
- R6: Reading the tag or the data of a slot whose index (address bits 11:0) is not below NUM_ENTRIES returns an error with zero data. A read of a slot in range returns the stored word.
- R7: When several slots hit, the lowest index is reported. Hit, index, tag and data appear in the same cycle as the address.
- R8: flush_o is high for exactly the response cycle of an invalidate that cleared at least one valid slot, and is low otherwise.
- R9: Each command produces rsp_valid_o one cycle later. The operation codes are 0 write, 1 read tag, 2 read data, 3 invalidate by address and 4 invalidate all. Any other code returns an error and has no effect.
- R10: After reset every slot's tag and data are zero, so every lookup misses.
- R11: Invalidate-by-address clears the valid bit of the slot that a lookup of the command address would report. With no hit, nothing changes and no flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seg1t_en_i | input | 1 | 1 TB segments permitted |
| lk_ea_i | input | 64 | Lookup effective address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | log2(NUM_ENTRIES) | Index of the hit slot |
| lk_tag_o | output | 64 | Tag word of the hit slot |
| lk_data_o | output | 64 | Data word of the hit slot |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code |
| cmd_addr_i | input | 64 | Address / tag operand |
| cmd_data_i | input | 64 | Data operand |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Command rejected |
| rsp_data_o | output | 64 | Read data |
| flush_o | output | 1 | Translation cache flush request |

## Verification
The bench builds the block with NUM_ENTRIES set to 8. With that size, slot numbers 8 and above can be reached with small operand values, so both the out-of-range rejection and a reserved-bit rejection can be driven directly. Eight slots also leave room for duplicate segments, a size-mismatch slot and a preserved slot 0 at the same time. With this arrangement, priority, invalidate-by-address against duplicates, and the survival of slot 0 under invalidate-all are all visible at the lookup port.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned V_BIT    = 27;
  localparam int unsigned S256_LSB = 28;
  localparam int unsigned S1T_LSB  = 40;
  localparam int unsigned SLOT_W   = 12;
  localparam int unsigned SZ_HI    = 63;
  localparam int unsigned SZ_LO    = 62;

  typedef enum logic [2:0] {
    OP_WRITE   = 3'd0,
    OP_RD_TAG  = 3'd1,
    OP_RD_DATA = 3'd2,
    OP_INV_ONE = 3'd3,
    OP_INV_ALL = 3'd4
  } slb_op_e;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_1T   = 2'b01
  } seg_size_e;

  function automatic logic [XLEN-1:0] seg_mask(input int unsigned lsb);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < int'(XLEN); i++) begin
      if (i >= int'(lsb)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [XLEN-1:0] vbit_word();
    logic [XLEN-1:0] m;
    m = '0;
    m[V_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [XLEN-1:0] ea_i,
  input  logic [XLEN-1:0] tag_i  [NUM_ENTRIES],
  input  logic [1:0]      size_i [NUM_ENTRIES],
  output logic            hit_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [XLEN-1:0] M256 = seg_mask(S256_LSB);
  localparam logic [XLEN-1:0] M1T  = seg_mask(S1T_LSB);
  localparam logic [XLEN-1:0] VW   = vbit_word();

  logic [XLEN-1:0] key256, key1t;
  logic [NUM_ENTRIES-1:0] match;

  assign key256 = (ea_i & M256) | VW;
  assign key1t  = (ea_i & M1T) | VW;

  for (genvar g = 0; g < int'(NUM_ENTRIES); g++) begin : g_cmp
    assign match[g] = ((tag_i[g] == key256) && (size_i[g] == SZ_256M)) ||
                      ((tag_i[g] == key1t)  && (size_i[g] == SZ_1T));
  end

  // lowest index wins
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = int'(NUM_ENTRIES) - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/slb_wr_check.sv
module slb_wr_check
  import slb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [XLEN-1:0]  addr_i,
  input  logic [XLEN-1:0]  data_i,
  input  logic             seg1t_en_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] slot_o
);
  // bits at and above log2(N) within the slot field must be clear
  localparam logic [SLOT_W-1:0] RSV = SLOT_W'(4096 - NUM_ENTRIES);

  logic       slot_bad, size_bad;
  logic [1:0] sz;

  assign sz       = data_i[SZ_HI:SZ_LO];
  assign slot_bad = |(addr_i[SLOT_W-1:0] & RSV);
  assign size_bad = sz[1] | (sz[0] & ~seg1t_en_i);
  assign ok_o     = ~slot_bad & ~size_bad;
  assign slot_o   = addr_i[IDX_W-1:0];
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg1t_en_i,
  input  logic [63:0]      lk_ea_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [63:0]      lk_tag_o,
  output logic [63:0]      lk_data_o,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [63:0]      cmd_addr_i,
  input  logic [63:0]      cmd_data_i,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic [63:0]      rsp_data_o,
  output logic             flush_o
);
  localparam logic [XLEN-1:0] KEEP = seg_mask(S256_LSB) | vbit_word();

  logic [XLEN-1:0] tag_q  [NUM_ENTRIES];
  logic [XLEN-1:0] data_q [NUM_ENTRIES];
  logic [XLEN-1:0] tag_d  [NUM_ENTRIES];
  logic [XLEN-1:0] data_d [NUM_ENTRIES];
  logic [1:0]      size_w [NUM_ENTRIES];

  for (genvar g = 0; g < int'(NUM_ENTRIES); g++) begin : g_sz
    assign size_w[g] = data_q[g][SZ_HI:SZ_LO];
  end

  // lookup port
  slb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk (
    .ea_i  (lk_ea_i),
    .tag_i (tag_q),
    .size_i(size_w),
    .hit_o (lk_hit_o),
    .idx_o (lk_idx_o)
  );
  assign lk_tag_o  = lk_hit_o ? tag_q[lk_idx_o]  : '0;
  assign lk_data_o = lk_hit_o ? data_q[lk_idx_o] : '0;

  // invalidate-by-address search
  logic             inv_hit;
  logic [IDX_W-1:0] inv_idx;
  slb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_inv (
    .ea_i  (cmd_addr_i),
    .tag_i (tag_q),
    .size_i(size_w),
    .hit_o (inv_hit),
    .idx_o (inv_idx)
  );

  logic             wr_ok;
  logic [IDX_W-1:0] wr_slot;
  slb_wr_check #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk_wr (
    .addr_i    (cmd_addr_i),
    .data_i    (cmd_data_i),
    .seg1t_en_i(seg1t_en_i),
    .ok_o      (wr_ok),
    .slot_o    (wr_slot)
  );

  logic             rd_ok;
  logic [IDX_W-1:0] rd_slot;
  assign rd_ok   = {1'b0, cmd_addr_i[SLOT_W-1:0]} < (SLOT_W+1)'(NUM_ENTRIES);
  assign rd_slot = cmd_addr_i[IDX_W-1:0];

  slb_op_e         op;
  logic            err_d, flush_d;
  logic [XLEN-1:0] rdata_d;

  assign op = slb_op_e'(cmd_op_i);

  always_comb begin
    for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
      tag_d[i]  = tag_q[i];
      data_d[i] = data_q[i];
    end
    err_d   = 1'b0;
    flush_d = 1'b0;
    rdata_d = '0;
    if (cmd_valid_i) begin
      case (op)
        OP_WRITE: begin
          if (wr_ok) begin
            tag_d[wr_slot]  = cmd_addr_i & KEEP;
            data_d[wr_slot] = cmd_data_i;
          end else begin
            err_d = 1'b1;
          end
        end
        OP_RD_TAG: begin
          if (rd_ok) rdata_d = tag_q[rd_slot];
          else       err_d   = 1'b1;
        end
        OP_RD_DATA: begin
          if (rd_ok) rdata_d = data_q[rd_slot];
          else       err_d   = 1'b1;
        end
        OP_INV_ONE: begin
          if (inv_hit) begin
            tag_d[inv_idx][V_BIT] = 1'b0;
            flush_d = 1'b1;
          end
        end
        OP_INV_ALL: begin
          // slot 0 is always kept
          for (int i = 1; i < int'(NUM_ENTRIES); i++) begin
            if (tag_q[i][V_BIT]) flush_d = 1'b1;
            tag_d[i][V_BIT] = 1'b0;
          end
        end
        default: err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
      flush_o     <= 1'b0;
    end else begin
      for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
        tag_q[i]  <= tag_d[i];
        data_q[i] <= data_d[i];
      end
      rsp_valid_o <= cmd_valid_i;
      rsp_err_o   <= err_d;
      rsp_data_o  <= rdata_d;
      flush_o     <= flush_d;
    end
  end
endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk
  import slb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [2:0]  cmd_op_i,
  input logic [63:0] cmd_addr_i,
  input logic [63:0] cmd_data_i,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic [63:0] rsp_data_o,
  input logic        flush_o,
  input logic        lk_hit_o,
  input logic [63:0] lk_tag_o,
  input logic [63:0] lk_data_o,
  input logic        v0_i
);
  logic slot_hi, is_rd;
  assign slot_hi = {1'b0, cmd_addr_i[SLOT_W-1:0]} >= (SLOT_W+1)'(NUM_ENTRIES);
  assign is_rd   = (cmd_op_i == OP_RD_TAG) || (cmd_op_i == OP_RD_DATA);

  p_rsp_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);
  p_no_spurious_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);
  p_slot_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_WRITE && slot_hi) |=> rsp_err_o);
  p_size_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_WRITE && cmd_data_i[SZ_HI]) |=> rsp_err_o);
  p_rd_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && is_rd && slot_hi) |=> (rsp_err_o && rsp_data_o == '0));
  p_slot0_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_INV_ALL && v0_i) |=> v0_i);
  p_flush_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(cmd_valid_i) &&
                 ($past(cmd_op_i) == OP_INV_ONE || $past(cmd_op_i) == OP_INV_ALL)));
  p_hit_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_tag_o[V_BIT] && !lk_data_o[SZ_HI]));
endmodule

bind slb_array slb_array_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_addr_i (cmd_addr_i),
  .cmd_data_i (cmd_data_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_data_o (rsp_data_o),
  .flush_o    (flush_o),
  .lk_hit_o   (lk_hit_o),
  .lk_tag_o   (lk_tag_o),
  .lk_data_o  (lk_data_o),
  .v0_i       (tag_q[0][slb_pkg::V_BIT])
);

// File: tb/sim_slb_array.sv
module sim_slb_array;
  localparam int N = 8;
  localparam logic [2:0] WR = 3'd0, RT = 3'd1, RD = 3'd2, IO = 3'd3, IA = 3'd4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        seg1t_en = 1'b1;
  logic [63:0] lk_ea = '0;
  logic        lk_hit;
  logic [2:0]  lk_idx;
  logic [63:0] lk_tag, lk_data;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [63:0] cmd_addr = '0, cmd_data = '0;
  logic        rsp_valid, rsp_err, flush;
  logic [63:0] rsp_data;

  always #2 clk = ~clk;

  slb_array #(.NUM_ENTRIES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .seg1t_en_i(seg1t_en),
    .lk_ea_i(lk_ea), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx),
    .lk_tag_o(lk_tag), .lk_data_o(lk_data),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
    .cmd_data_i(cmd_data), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_data_o(rsp_data), .flush_o(flush)
  );

  typedef struct {
    logic        err;
    logic [63:0] data;
    logic        flush;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", "unexpected response", 64'd1, 64'd0);
      end else begin
        e = q.pop_front();
        chk(rsp_err == e.err, e.req, "rsp_err", 64'(rsp_err), 64'(e.err));
        chk(rsp_data == e.data, e.req, "rsp_data", rsp_data, e.data);
        chk(flush == e.flush, e.req, "flush", 64'(flush), 64'(e.flush));
      end
    end
  end

  // driver
  task automatic cmd(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d,
                     input logic ee, input logic [63:0] ed, input logic ef, input string r);
    exp_t x;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    x.err = ee; x.data = ed; x.flush = ef; x.req = r;
    q.push_back(x);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic look(input logic [63:0] ea, input logic eh, input logic [2:0] ei,
                      input logic [63:0] ed, input string r);
    lk_ea = ea;
    #1;
    chk(lk_hit == eh, r, "lk_hit", 64'(lk_hit), 64'(eh));
    if (eh) begin
      chk(lk_idx == ei, r, "lk_idx", 64'(lk_idx), 64'(ei));
      chk(lk_data == ed, r, "lk_data", lk_data, ed);
    end
  endtask

  localparam logic [63:0] D1 = 64'h0000_ABCD_0000_0F00;
  localparam logic [63:0] D2 = 64'h4000_0000_1234_5000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    look(64'h0000_0000_0000_0000, 1'b0, 3'd0, '0, "R10");
    cmd(RT, 64'd0, '0, 1'b0, '0, 1'b0, "R10");
    cmd(RD, 64'd7, '0, 1'b0, '0, 1'b0, "R10");
    // R4 write with junk in bits 26:12
    cmd(WR, 64'h1234_5678_9801_2001, D1, 1'b0, '0, 1'b0, "R4");
    cmd(RT, 64'd1, '0, 1'b0, 64'h1234_5678_9800_0000, 1'b0, "R4");
    cmd(RD, 64'd1, '0, 1'b0, D1, 1'b0, "R4");
    // R1 256M hit / miss
    look(64'h1234_5678_9ABC_DEF0, 1'b1, 3'd1, D1, "R1");
    look(64'h1234_5678_A000_0000, 1'b0, 3'd0, '0, "R1");
    // R1 1T entry
    cmd(WR, 64'h00AB_CD00_0800_0002, D2, 1'b0, '0, 1'b0, "R1");
    look(64'h00AB_CD12_3456_7890, 1'b1, 3'd2, D2, "R1");
    // R7 duplicate in slot 3, lowest wins
    cmd(WR, 64'h00AB_CD00_0800_0003, D2 | 64'h1, 1'b0, '0, 1'b0, "R7");
    look(64'h00AB_CD99_0000_0000, 1'b1, 3'd2, D2, "R7");
    // R1 size field mismatch: 256M slot whose tag equals the 1T key
    cmd(WR, 64'h5500_0000_0800_0004, 64'h0, 1'b0, '0, 1'b0, "R1");
    look(64'h5500_0012_3000_0000, 1'b0, 3'd0, '0, "R1");
    // R2 slot range and reserved bit
    cmd(WR, 64'h0000_0000_0800_0008, D1, 1'b1, '0, 1'b0, "R2");
    cmd(WR, 64'h6600_0000_0800_0016, D1, 1'b1, '0, 1'b0, "R2");
    cmd(RT, 64'd6, '0, 1'b0, '0, 1'b0, "R2");
    look(64'h6600_0000_0000_0000, 1'b0, 3'd0, '0, "R2");
    // R3 size encodings
    cmd(WR, 64'h6600_0000_0800_0006, 64'h8000_0000_0000_0000, 1'b1, '0, 1'b0, "R3");
    cmd(WR, 64'h6600_0000_0800_0006, 64'hC000_0000_0000_0000, 1'b1, '0, 1'b0, "R3");
    seg1t_en = 1'b0;
    cmd(WR, 64'h6600_0000_0800_0006, 64'h4000_0000_0000_0000, 1'b1, '0, 1'b0, "R3");
    seg1t_en = 1'b1;
    cmd(RD, 64'd6, '0, 1'b0, '0, 1'b0, "R3");
    // R6 read out of range
    cmd(RT, 64'd8, '0, 1'b1, '0, 1'b0, "R6");
    cmd(RD, 64'hFFF, '0, 1'b1, '0, 1'b0, "R6");
    // R9 undefined op
    cmd(3'd5, 64'h1234_5678_9000_0000, '0, 1'b1, '0, 1'b0, "R9");
    look(64'h1234_5678_9ABC_DEF0, 1'b1, 3'd1, D1, "R9");
    // R11 invalidate by address
    cmd(IO, 64'h1234_5678_9000_0000, '0, 1'b0, '0, 1'b1, "R11");
    look(64'h1234_5678_9ABC_DEF0, 1'b0, 3'd0, '0, "R11");
    cmd(RT, 64'd1, '0, 1'b0, 64'h1234_5678_9000_0000, 1'b0, "R11");
    cmd(IO, 64'h1234_5678_9000_0000, '0, 1'b0, '0, 1'b0, "R8");
    cmd(IO, 64'h00AB_CD12_0000_0000, '0, 1'b0, '0, 1'b1, "R11");
    look(64'h00AB_CD12_0000_0000, 1'b1, 3'd3, D2 | 64'h1, "R11");
    // R5 invalidate all, slot 0 kept
    cmd(WR, 64'h7700_0000_0800_0000, 64'h0, 1'b0, '0, 1'b0, "R5");
    cmd(IA, '0, '0, 1'b0, '0, 1'b1, "R5");
    look(64'h7700_0000_0000_1234, 1'b1, 3'd0, 64'h0, "R5");
    look(64'h00AB_CD12_0000_0000, 1'b0, 3'd0, '0, "R5");
    cmd(RT, 64'd3, '0, 1'b0, 64'h00AB_CD00_0000_0000, 1'b0, "R5");
    cmd(IA, '0, '0, 1'b0, '0, 1'b0, "R8");
    look(64'h7700_0000_0FFF_FFFF, 1'b1, 3'd0, 64'h0, "R5");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9", "pending responses", 64'(q.size()), 64'd0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R9", "watchdog expired", 64'd1, 64'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule